// File: doc/BRIEF.md
# Cascadable Parity Transceiver

This block computes and checks parity over a data word built from nine-lane parity units. Each unit has one shared parity pin. A single mode input decides whether that pin is driven or sampled. In generate mode the unit drives its parity result onto the pin and forces its active-low error flag inactive. In check mode the unit releases the pin, reads the parity bit from the bus, and compares it with the parity of its own data lanes.

The bidirectional pin is split into three signals: a data-out, an output-enable and a data-in. This keeps the logic free of internal tri-states. The pad is expected at the chip edge.

Words wider than nine bits are handled by chaining units. Every lower unit runs in generate mode. Its parity result feeds the ninth lane of the unit above it. Only the last unit sees the external mode input and the external pin. The whole block is combinational and holds no state.

Top module: `par_cascade`

## Requirements
- R1: In generate mode (`chk_sel_i` = 0), a single unit drives `par_pin_o` = 1 when an even number of its nine lanes are 1, and drives 0 when the number is odd.
- R2: `par_pin_oe` is 1 when `chk_sel_i` = 0 and 0 when `chk_sel_i` = 1. It follows the mode input with no clock.
- R3: In generate mode, `err_n_o` is 1 for every data pattern and every `par_pin_i` level. The data and the pin have no effect on it.
- R4: In check mode, `err_n_o` is 0 when an even number of lanes are 1 and `par_pin_i` = 0.
- R5: In check mode, `err_n_o` is 0 when an odd number of lanes are 1 and `par_pin_i` = 1. In the other two check-mode cases (even count with the pin at 1, odd count with the pin at 0) it is 1.
- R6: With STAGES chained units, the word is W = 9 + 8*(STAGES-1) bits wide. Unit 0 takes bits [8:0]. Unit k (k ≥ 1) takes eight new bits from `data_i[9+8*(k-1) +: 8]` on lanes 0..7, and the parity output of unit k-1 on lane 8. As a result, `par_pin_o` equals the XNOR-reduction of `data_i` when STAGES is odd, and the XOR-reduction when STAGES is even.
- R7: In a cascade in check mode, `err_n_o` is 0 exactly when `par_pin_i` differs from the value `par_pin_o` carries for the same data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_i | input | W | Data word; W = 9 + 8*(STAGES-1) |
| chk_sel_i | input | 1 | Mode: 0 = generate (drive pin), 1 = check (sample pin) |
| par_pin_i | input | 1 | Level read back from the parity pin |
| par_pin_o | output | 1 | Parity value offered to the pin |
| par_pin_oe | output | 1 | Pin drive enable, active high |
| err_n_o | output | 1 | Parity error flag, active low |

## Verification
A single-unit instance is swept over all 512 lane patterns. Each pattern is tried in both modes and at both pin levels. This separates even counts from odd counts, driven levels from sampled levels, and the two error cases from the two quiet cases. A three-unit instance is driven with a long pseudo-random sequence of 25-bit words, plus the all-zero and all-one words. Its driven parity and its error flag are compared with a plain reduction of the whole word. This catches a miswired chain lane or a wrong polarity in the cascade.

// File: rtl/par_pkg.sv
package par_pkg;
  localparam int unsigned LANES = 9;

  typedef enum logic {
    MODE_GEN = 1'b0,
    MODE_CHK = 1'b1
  } par_mode_e;

  function automatic int unsigned word_width(input int unsigned stages);
    return LANES + (LANES - 1) * (stages - 1);
  endfunction
endpackage

// File: rtl/par_tree.sv
module par_tree #(
  parameter int unsigned N = 9
) (
  input  logic [N-1:0] bits_i,
  output logic         odd_o
);
  localparam int unsigned NODES = 2 * N - 1;

  // heap-ordered balanced XOR tree: leaves at N-1 .. 2N-2
  logic node [NODES];

  for (genvar j = 0; j < N; j++) begin : g_leaf
    assign node[N-1+j] = bits_i[j];
  end

  for (genvar i = 0; i < N - 1; i++) begin : g_node
    assign node[i] = node[2*i+1] ^ node[2*i+2];
  end

  assign odd_o = node[0];
endmodule

// File: rtl/par_unit.sv
module par_unit
  import par_pkg::*;
(
  input  logic [LANES-1:0] lanes_i,
  input  logic             chk_sel_i,
  input  logic             pin_i,
  output logic             pin_o,
  output logic             err_n_o
);
  logic      odd;
  logic      even_hi;
  par_mode_e mode;

  par_tree #(.N(LANES)) u_tree (
    .bits_i (lanes_i),
    .odd_o  (odd)
  );

  always_comb begin
    mode    = par_mode_e'(chk_sel_i);
    even_hi = ~odd;
    pin_o   = even_hi;
    if (mode == MODE_GEN) begin
      err_n_o = 1'b1;
    end else begin
      err_n_o = (even_hi == pin_i);
    end
  end
endmodule

// File: rtl/par_cascade.sv
module par_cascade
  import par_pkg::*;
#(
  parameter int unsigned STAGES = 3,
  localparam int unsigned W = word_width(STAGES)
) (
  input  logic [W-1:0] data_i,
  input  logic         chk_sel_i,
  input  logic         par_pin_i,
  output logic         par_pin_o,
  output logic         par_pin_oe,
  output logic         err_n_o
);
  logic [STAGES-1:0] link;
  logic [STAGES-1:0] err_v;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    logic [LANES-1:0] lanes;
    logic             sel;
    logic             pin_rd;

    if (k == 0) begin : g_first
      assign lanes = data_i[LANES-1:0];
    end else begin : g_next
      assign lanes = {link[k-1], data_i[LANES+(LANES-1)*(k-1) +: LANES-1]};
    end

    if (k == STAGES - 1) begin : g_top
      assign sel    = chk_sel_i;
      assign pin_rd = par_pin_i;
    end else begin : g_low
      assign sel    = MODE_GEN;
      assign pin_rd = 1'b0;
    end

    par_unit u_unit (
      .lanes_i   (lanes),
      .chk_sel_i (sel),
      .pin_i     (pin_rd),
      .pin_o     (link[k]),
      .err_n_o   (err_v[k])
    );
  end

  assign par_pin_o  = link[STAGES-1];
  assign par_pin_oe = (par_mode_e'(chk_sel_i) == MODE_GEN);
  assign err_n_o    = &err_v;
endmodule

// File: rtl/par_cascade_chk.sv
module par_cascade_chk
  import par_pkg::*;
#(
  parameter int unsigned STAGES = 3,
  localparam int unsigned W = word_width(STAGES)
) (
  input logic [W-1:0] data_i,
  input logic         chk_sel_i,
  input logic         par_pin_i,
  input logic         par_pin_o,
  input logic         par_pin_oe,
  input logic         err_n_o
);
  localparam logic POL = logic'(STAGES % 2);

  always_comb begin
    p_oe_mode_r2: assert (par_pin_oe == !chk_sel_i)
      else $error("oe does not track mode");
    if (!chk_sel_i) begin
      p_err_idle_gen_r3: assert (err_n_o)
        else $error("error flagged in generate mode");
    end
    if (chk_sel_i) begin
      p_err_mismatch_r7: assert (err_n_o == (par_pin_o == par_pin_i))
        else $error("error flag disagrees with pin compare");
    end
    p_word_parity_r6: assert (par_pin_o == ((^data_i) ^ POL))
      else $error("cascade parity polarity wrong");
  end
endmodule

bind par_cascade par_cascade_chk #(.STAGES(STAGES)) u_chk (
  .data_i     (data_i),
  .chk_sel_i  (chk_sel_i),
  .par_pin_i  (par_pin_i),
  .par_pin_o  (par_pin_o),
  .par_pin_oe (par_pin_oe),
  .err_n_o    (err_n_o)
);

// File: tb/sim_par_cascade.sv
module sim_par_cascade;
  localparam int unsigned S1 = 1;
  localparam int unsigned W1 = 9;
  localparam int unsigned S3 = 3;
  localparam int unsigned W3 = 25;

  logic clk;
  logic rst_n;
  int   checks;
  int   failures;
  bit   done;

  logic [W1-1:0] d1;
  logic          sel1, pin1;
  logic          po1, oe1, err1;
  logic [W3-1:0] d3;
  logic          sel3, pin3;
  logic          po3, oe3, err3;

  par_cascade #(.STAGES(S1)) u0 (
    .data_i (d1), .chk_sel_i (sel1), .par_pin_i (pin1),
    .par_pin_o (po1), .par_pin_oe (oe1), .err_n_o (err1)
  );

  par_cascade #(.STAGES(S3)) u1 (
    .data_i (d3), .chk_sel_i (sel3), .par_pin_i (pin3),
    .par_pin_o (po3), .par_pin_oe (oe3), .err_n_o (err3)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b d1=%h d3=%h", req, act, exp, d1, d3);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic check_single(input logic [8:0] d, input logic sel, input logic pin);
    logic even;
    @(posedge clk); #1;
    d1 = d; sel1 = sel; pin1 = pin;
    @(negedge clk);
    even = ($countones(d) % 2) == 0;
    check("R2", oe1, !sel);
    if (!sel) begin
      check("R1", po1, even);
      check("R3", err1, 1'b1);
    end else if (even) begin
      check(pin ? "R5" : "R4", err1, pin);
    end else begin
      check("R5", err1, !pin);
    end
  endtask

  task automatic check_wide(input logic [W3-1:0] d, input logic sel, input logic pin);
    logic exp_par;
    @(posedge clk); #1;
    d3 = d; sel3 = sel; pin3 = pin;
    @(negedge clk);
    exp_par = ~(^d);
    check("R6", po3, exp_par);
    check("R2", oe3, !sel);
    if (sel) check("R7", err3, pin == exp_par);
    else     check("R3", err3, 1'b1);
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] lfsr;
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0;
    d1 = '0; sel1 = 1'b0; pin1 = 1'b0;
    d3 = '0; sel3 = 1'b0; pin3 = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1", po1, 1'b1);
    check("R2", oe1, 1'b1);
    check("R3", err1, 1'b1);

    for (int v = 0; v < 512; v++) begin
      for (int m = 0; m < 2; m++) begin
        for (int p = 0; p < 2; p++) begin
          check_single(9'(v), logic'(m), logic'(p));
        end
      end
    end

    for (int m = 0; m < 2; m++) begin
      for (int p = 0; p < 2; p++) begin
        check_wide('0, logic'(m), logic'(p));
        check_wide('1, logic'(m), logic'(p));
      end
    end

    lfsr = 32'hACE1_1357;
    for (int n = 0; n < 1500; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      for (int m = 0; m < 2; m++) begin
        for (int p = 0; p < 2; p++) begin
          check_wide(lfsr[W3-1:0], logic'(m), logic'(p));
        end
      end
    end

    finish_run();
  end
endmodule